// File: doc/BRIEF.md
# Serial Frequency/Phase Register Loader

This block takes 16-bit command words from a three-wire serial port and uses them to load a bank of tuning registers. The port has a serial clock, a serial data line and an active-low frame strobe. The bank holds two 32-bit frequency words and four 12-bit phase words. The serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the falling edges of the serial clock are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

A single shared 16-bit staging register sits between the port and the bank. It is made of a low byte and a high byte. A deferred write updates only the addressed byte of the staging register. A direct write first updates the addressed byte and then copies all 16 staged bits into the destination slot. This gives an atomic update of each 16-bit slot. After a full load, the staging register still holds the word that was written. A single direct write can therefore change just one byte of a slot.

The serial port carries no back-pressure. Every complete frame is accepted, and the outputs are plain register values with no handshake.

Top module: `ser_reg_loader`

## Requirements
- R1: After reset, both frequency outputs and all four phase outputs read zero.
- R2: A frame starts when the frame strobe goes low. It captures one data bit on each falling edge of the serial clock, most significant bit first, and is complete after 16 falling edges. Further falling edges are ignored until the strobe rises.
- R3: The frame is split into three fields. Bits [15:12] are the command, bits [11:8] are the address and bits [7:0] are the data byte. Command 4'b0010 is a deferred write and 4'b0011 is a direct write.
- R4: A deferred write loads the data byte into the staging byte selected by address bit 0 (0 = low byte, 1 = high byte). No output changes.
- R5: A direct write loads the addressed staging byte and then copies the whole 16-bit staging value to the destination slot selected by address bits [3:1]. The destination updates two system clocks after the frame completes.
- R6: Frequency mapping. Addresses 0/1 fill bits [15:0] of frequency word 0, and addresses 2/3 fill its bits [31:16]. Addresses 4 to 7 do the same for frequency word 1.
- R7: Phase mapping. Address pairs 8/9, 10/11, 12/13 and 14/15 load phase words 0 to 3. Each phase word takes only staging bits [11:0], so the upper 4 bits of the high byte have no effect.
- R8: The staging register keeps its value between frames. A direct write alone therefore combines the new byte with the byte left over from earlier frames.
- R9: Any command value other than 4'b0010 or 4'b0011 leaves both the staging register and all outputs unchanged.
- R10: A frame whose strobe rises before 16 falling edges is discarded with no side effects. The next full frame is received correctly.
- R11: The serial clock may idle either high or low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on serial clock falls |
| frame_n_i | input | 1 | Active-low frame strobe |
| freq0_o | output | 32 | Frequency word 0 |
| freq1_o | output | 32 | Frequency word 1 |
| phase0_o | output | 12 | Phase word 0 |
| phase1_o | output | 12 | Phase word 1 |
| phase2_o | output | 12 | Phase word 2 |
| phase3_o | output | 12 | Phase word 3 |

## Verification
The hardest condition to reach from the ports is a direct write that mixes its new byte with a stale staging byte left by an earlier frame. That stale byte may come from a different destination. The stimulus table reaches this by chaining writes so that lone direct writes land on slots whose other staging byte was set by an earlier write. Discarded frames are produced by raising the strobe after ten serial clock falls and then sending a full frame to show that the receiver recovered.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int FREQ_W   = 32;
  localparam int PHASE_W  = 12;
  localparam int NUM_FREQ = 2;
  localparam int NUM_PHASE = 4;
  localparam int HALVES_PER_FREQ = FREQ_W / WORD_W;
  localparam int FREQ_SLOTS = NUM_FREQ * HALVES_PER_FREQ;
  localparam int NUM_SLOTS  = FREQ_SLOTS + NUM_PHASE;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);

  localparam logic [3:0] CMD_DEFER  = 4'b0010;
  localparam logic [3:0] CMD_DIRECT = 4'b0011;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [3:0]        addr;
    logic [BYTE_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sreg_deframer.sv
module sreg_deframer #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              frame_n_i,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sr, sdat_sr, frm_sr;
  logic sclk_s, sdat_s, frm_s, sclk_d, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      sdat_sr <= '0;
      frm_sr  <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk_i};
      sdat_sr <= {sdat_sr[SYNC_STAGES-2:0], sdata_i};
      frm_sr  <= {frm_sr[SYNC_STAGES-2:0], frame_n_i};
      sclk_d  <= sclk_s;
    end
  end

  assign sclk_s    = sclk_sr[SYNC_STAGES-1];
  assign sdat_s    = sdat_sr[SYNC_STAGES-1];
  assign frm_s     = frm_sr[SYNC_STAGES-1];
  assign sclk_fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shift_q  <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (frm_s) begin
        bit_cnt <= '0;
      end else if (sclk_fall && bit_cnt != CNT_W'(WORD_W)) begin
        shift_q <= {shift_q[WORD_W-2:0], sdat_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(WORD_W - 1)) word_vld <= 1'b1;
      end
    end
  end

  assign word = shift_q;

  // R10
  strobe_high_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_s |=> !word_vld);
  // R2
  word_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(sclk_fall));
endmodule

// File: rtl/sreg_defer_stage.sv
module sreg_defer_stage
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  frame_t            frm,
  output logic              commit_vld,
  output logic [SLOT_W-1:0] commit_slot,
  output logic [WORD_W-1:0] commit_data
);
  logic [WORD_W-1:0] stage_q, merged;
  logic is_defer, is_direct, hi_half;

  assign is_defer  = (frm.cmd == CMD_DEFER);
  assign is_direct = (frm.cmd == CMD_DIRECT);
  assign hi_half   = frm.addr[0];

  always_comb begin
    merged = stage_q;
    if (hi_half) merged[WORD_W-1:BYTE_W] = frm.data;
    else         merged[BYTE_W-1:0]      = frm.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q     <= '0;
      commit_vld  <= 1'b0;
      commit_slot <= '0;
      commit_data <= '0;
    end else begin
      commit_vld <= 1'b0;
      if (word_vld && (is_defer || is_direct)) stage_q <= merged;
      if (word_vld && is_direct) begin
        commit_vld  <= 1'b1;
        commit_slot <= SLOT_W'(frm.addr[3:1]);
        commit_data <= merged;
      end
    end
  end

  // R4
  defer_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && is_defer) |=> !commit_vld);
  // R5
  direct_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && is_direct) |=> commit_vld);
  // R9
  other_cmd_keeps_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !is_defer && !is_direct) |=> ($stable(stage_q) && !commit_vld));
endmodule

// File: rtl/sreg_dest_bank.sv
module sreg_dest_bank
  import sreg_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_vld,
  input  logic [SLOT_W-1:0]                 commit_slot,
  input  logic [WORD_W-1:0]                 commit_data,
  output logic [NUM_FREQ-1:0][FREQ_W-1:0]   freq,
  output logic [NUM_PHASE-1:0][PHASE_W-1:0] phase
);
  logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_val;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < FREQ_SLOTS) begin : g_freq
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (commit_vld && commit_slot == SLOT_W'(s)) q <= commit_data;
      end
      assign slot_val[s] = q;
    end else begin : g_phase
      logic [PHASE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (commit_vld && commit_slot == SLOT_W'(s)) q <= commit_data[PHASE_W-1:0];
      end
      assign slot_val[s] = {{(WORD_W-PHASE_W){1'b0}}, q};
    end
  end

  for (genvar f = 0; f < NUM_FREQ; f++) begin : g_fout
    for (genvar h = 0; h < HALVES_PER_FREQ; h++) begin : g_half
      assign freq[f][h*WORD_W +: WORD_W] = slot_val[f*HALVES_PER_FREQ + h];
    end
  end
  for (genvar p = 0; p < NUM_PHASE; p++) begin : g_pout
    assign phase[p] = slot_val[FREQ_SLOTS + p][PHASE_W-1:0];
  end

  // R4
  idle_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_vld |=> $stable(slot_val));
  // R6
  freq_commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && commit_slot < SLOT_W'(FREQ_SLOTS)) |=>
      slot_val[$past(commit_slot)] == $past(commit_data));
endmodule

// File: rtl/ser_reg_loader.sv
module ser_reg_loader
  import sreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               frame_n_i,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic [PHASE_W-1:0] phase2_o,
  output logic [PHASE_W-1:0] phase3_o
);
  logic              word_vld, commit_vld;
  logic [WORD_W-1:0] word, commit_data;
  logic [SLOT_W-1:0] commit_slot;
  logic [NUM_FREQ-1:0][FREQ_W-1:0]   freq;
  logic [NUM_PHASE-1:0][PHASE_W-1:0] phase;

  sreg_deframer #(.SYNC_STAGES(2), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .frame_n_i(frame_n_i), .word_vld(word_vld), .word(word)
  );

  sreg_defer_stage u_stage (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .frm(frame_t'(word)),
    .commit_vld(commit_vld), .commit_slot(commit_slot), .commit_data(commit_data)
  );

  sreg_dest_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit_vld(commit_vld), .commit_slot(commit_slot),
    .commit_data(commit_data), .freq(freq), .phase(phase)
  );

  assign freq0_o  = freq[0];
  assign freq1_o  = freq[1];
  assign phase0_o = phase[0];
  assign phase1_o = phase[1];
  assign phase2_o = phase[2];
  assign phase3_o = phase[3];
endmodule

// File: tb/ser_reg_loader_test.sv
module ser_reg_loader_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SCLK_HALF  = 4;
  localparam int  NVEC = 14;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2012, 16'h3134, 16'h2256, 16'h3378, 16'h2499, 16'h35AA, 16'h37CC,
    16'h28BC, 16'h39FF, 16'h3A55, 16'h2C21, 16'h3D03, 16'h3F0A, 16'h5E77
  };

  logic clk = 0, rst_n = 0, sclk = 1, sdata = 0, frame_n = 1;
  logic [31:0] freq0, freq1;
  logic [11:0] ph0, ph1, ph2, ph3;
  int tests = 0, fails = 0;

  logic [15:0] m_stage;
  logic [31:0] m_f0, m_f1;
  logic [11:0] m_p [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_reg_loader uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .frame_n_i(frame_n),
    .freq0_o(freq0), .freq1_o(freq1), .phase0_o(ph0), .phase1_o(ph1),
    .phase2_o(ph2), .phase3_o(ph3)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input logic idle_lvl);
    sclk = idle_lvl;
    wait_clk(SCLK_HALF);
    frame_n = 0;
    wait_clk(SCLK_HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk  = 1;
      sdata = w[15-i];
      wait_clk(SCLK_HALF);
      sclk = 0;
      wait_clk(SCLK_HALF);
    end
    sclk = 1;
    wait_clk(SCLK_HALF);
    frame_n = 1;
    sclk = idle_lvl;
    wait_clk(12);
  endtask

  task automatic model(input logic [15:0] w);
    logic [3:0] cmd, addr;
    cmd = w[15:12];
    addr = w[11:8];
    if (cmd == 4'b0010 || cmd == 4'b0011) begin
      if (addr[0]) m_stage[15:8] = w[7:0];
      else         m_stage[7:0]  = w[7:0];
      if (cmd == 4'b0011) begin
        case (addr[3:1])
          3'd0: m_f0[15:0]  = m_stage;
          3'd1: m_f0[31:16] = m_stage;
          3'd2: m_f1[15:0]  = m_stage;
          3'd3: m_f1[31:16] = m_stage;
          default: m_p[addr[3:1]-3'd4] = m_stage[11:0];
        endcase
      end
    end
  endtask

  task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [111:0] outs();
    return {freq0, freq1, ph0, ph1, ph2, ph3};
  endfunction

  function automatic logic [111:0] expd();
    return {m_f0, m_f1, m_p[0], m_p[1], m_p[2], m_p[3]};
  endfunction

  task automatic run(input string req, input logic [15:0] w);
    send(w, 16, 1'b1);
    model(w);
    check(req, outs(), expd());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_stage = '0; m_f0 = '0; m_f1 = '0;
    for (int i = 0; i < 4; i++) m_p[i] = '0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    check("R1 reset", outs(), 112'h0);

    for (int i = 0; i < NVEC; i++) run("R5 table", VEC[i]);

    check("R6 freq0", {80'h0, freq0}, {80'h0, 32'h78563412});
    check("R6 freq1", {80'h0, freq1}, {80'h0, 32'hCC99AA99});
    check("R7 phase0 upper nibble dropped", {100'h0, ph0}, {100'h0, 12'hFBC});
    check("R7 phase3", {100'h0, ph3}, {100'h0, 12'hA21});

    run("R4 deferred only", 16'h2101);
    run("R8 lone direct", 16'h3002);
    check("R8 freq0 merged", {80'h0, freq0}, {80'h0, 32'h78560102});

    run("R9 cmd 0100", 16'h4312);
    run("R9 cmd 0000", 16'h0044);
    run("R9 stage kept", 16'h3E66);

    send(16'h3155, 10, 1'b1);
    check("R10 short frame dropped", outs(), expd());
    run("R10 recovery", 16'h3398);

    run("R2 R3 bit order", 16'h31A5);
    check("R2 R3 byte position", {104'h0, freq0[15:8]}, {104'h0, 8'hA5});

    send(16'h3BC3, 16, 1'b0);
    model(16'h3BC3);
    check("R11 idle low", outs(), expd());

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule